// File: doc/BRIEF.md
# Buffered Two-Wire Channel Switch

This block is a synchronous model of a switch that connects one upstream two-wire bus to up to four downstream channels. Each line is open-drain. The model represents a line as a sampled level input (1 = high, 0 = low) and a pull-low drive output (1 = pull the line low). A channel-enable vector and a clock-direction bit come from a separate control register. They decide which channels are connected and which way the clock flows.

The clock path goes one way only.

- Forward direction: the upstream clock is copied onto the enabled downstream clocks.
- Reverse direction: the enabled downstream clocks are combined and driven upstream.

The data path goes both ways. A lock state machine gives ownership to the side that pulls low first. It holds that ownership until the owning side releases. It then passes through a release cycle and an idle cycle before it picks a new owner. When the opposite side is still low at that point, it takes over, and the formerly owning side sees a short high gap followed by a low hand-over pulse.

Top module: `twi_fanout_switch`

## Requirements
- R1: While `rst_ni` is low, every drive output is 0, whatever the line levels. After reset the lock is idle, all channels are released and the clock is in forward mode.
- R2: A channel whose bit in `chan_en_i` is 0 never has its clock or data drive asserted. A low on its lines has no effect on any upstream drive.
- R3: With `clk_rev_i` = 0, `dn_scl_drv_o[n]` is 1 in the cycle after a clock edge that sampled `up_scl_i` low with `chan_en_i[n]` = 1. Otherwise it is 0.
- R4: With `clk_rev_i` = 1, `up_scl_drv_o` is 1 in the cycle after a clock edge that sampled at least one enabled downstream clock line low. In this mode `dn_scl_drv_o` is 0.
- R5: In forward mode `up_scl_drv_o` stays 0 even when downstream clocks are held low, so stretching is never passed back.
- R6: When the upstream data line is sampled low while the lock is idle, the lock becomes upstream-owned from the next cycle. Every enabled `dn_sda_drv_o` bit is then 1 and `up_sda_drv_o` is 0, even if downstream lines are low.
- R7: When an enabled downstream data line is sampled low while the lock is idle and upstream is high, the lock becomes downstream-owned. `up_sda_drv_o` is then 1 and `dn_sda_drv_o` is 0.
- R8: Ownership ends only after the owning side is sampled high. Its drive then drops for a release cycle and an idle cycle before a new owner can be chosen. A side that is still low at that point takes over, which gives a hand-over low pulse on the old owner side after a two-cycle high gap.
- R9: If both sides are sampled low in the same cycle while idle, the upstream side wins.
- R10: The downstream data input is the wired-AND of the enabled channels. Ownership on that side lasts while any enabled channel is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| chan_en_i | input | 4 | Per-channel connect enable |
| clk_rev_i | input | 1 | Clock direction, 1 = downstream to upstream |
| up_scl_i | input | 1 | Upstream clock line level |
| up_scl_drv_o | output | 1 | Pull upstream clock low |
| up_sda_i | input | 1 | Upstream data line level |
| up_sda_drv_o | output | 1 | Pull upstream data low |
| dn_scl_i | input | 4 | Downstream clock line levels |
| dn_scl_drv_o | output | 4 | Pull downstream clock lines low |
| dn_sda_i | input | 4 | Downstream data line levels |
| dn_sda_drv_o | output | 4 | Pull downstream data lines low |

## Verification
The bench models each line as open-drain and feeds the block's own drives back onto its inputs. Without this, a switch that samples its own driven low would lock onto itself and never release. The bench follows the release and hand-over sequence cycle by cycle:

- A design with no release gap would show the hand-over pulse one cycle early.
- A design that ignores the tie rule would hand the bus to the downstream side.

Disabled channels held low check that the wired-AND ignores them; a design that did not would stall the data lock. Forward mode with downstream clocks held low catches a clock path that passes stretching back upstream.

// File: rtl/twi_sw_pkg.sv
package twi_sw_pkg;
  typedef enum logic [1:0] {
    LK_IDLE = 2'd0,
    LK_UP   = 2'd1,
    LK_DN   = 2'd2,
    LK_REL  = 2'd3
  } lock_st_e;
endpackage

// File: rtl/twi_clk_router.sv
module twi_clk_router #(
  parameter int NCH = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] en_i,
  input  logic           rev_i,
  input  logic           up_scl_i,
  input  logic [NCH-1:0] dn_scl_i,
  output logic           up_scl_drv_o,
  output logic [NCH-1:0] dn_scl_drv_o
);
  localparam logic [NCH-1:0] NONE = '0;

  logic [NCH-1:0] dn_low;
  assign dn_low = en_i & ~dn_scl_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_scl_drv_o <= 1'b0;
      dn_scl_drv_o <= NONE;
    end else begin
      // forward: fan out; reverse: wired-AND of enabled channels
      dn_scl_drv_o <= (!rev_i && !up_scl_i) ? en_i : NONE;
      up_scl_drv_o <= rev_i && (dn_low != NONE);
    end
  end
endmodule

// File: rtl/twi_dn_merge.sv
module twi_dn_merge #(
  parameter int NCH = 4
) (
  input  logic [NCH-1:0] en_i,
  input  logic [NCH-1:0] dn_sda_i,
  input  logic           up_own_i,
  output logic           dn_low_o,
  output logic [NCH-1:0] dn_sda_drv_o
);
  logic [NCH-1:0] ch_low;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign ch_low[g]       = en_i[g] & ~dn_sda_i[g];
    assign dn_sda_drv_o[g] = en_i[g] & up_own_i;
  end

  assign dn_low_o = |ch_low;
endmodule

// File: rtl/twi_sda_lock.sv
module twi_sda_lock
  import twi_sw_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic up_low_i,
  input  logic dn_low_i,
  output logic up_own_o,
  output logic dn_own_o
);
  lock_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      LK_IDLE: begin
        if (up_low_i)      st_d = LK_UP;   // upstream wins ties
        else if (dn_low_i) st_d = LK_DN;
      end
      LK_UP:   if (!up_low_i) st_d = LK_REL;
      LK_DN:   if (!dn_low_i) st_d = LK_REL;
      LK_REL:  st_d = LK_IDLE;             // let own driven low clear
      default: st_d = LK_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= LK_IDLE;
    else         st_q <= st_d;
  end

  assign up_own_o = (st_q == LK_UP);
  assign dn_own_o = (st_q == LK_DN);
endmodule

// File: rtl/twi_fanout_switch.sv
module twi_fanout_switch #(
  parameter int NCH = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] chan_en_i,
  input  logic           clk_rev_i,
  input  logic           up_scl_i,
  output logic           up_scl_drv_o,
  input  logic           up_sda_i,
  output logic           up_sda_drv_o,
  input  logic [NCH-1:0] dn_scl_i,
  output logic [NCH-1:0] dn_scl_drv_o,
  input  logic [NCH-1:0] dn_sda_i,
  output logic [NCH-1:0] dn_sda_drv_o
);
  logic dn_low, up_own, dn_own;

  twi_clk_router #(.NCH(NCH)) u_clk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (chan_en_i),
    .rev_i        (clk_rev_i),
    .up_scl_i     (up_scl_i),
    .dn_scl_i     (dn_scl_i),
    .up_scl_drv_o (up_scl_drv_o),
    .dn_scl_drv_o (dn_scl_drv_o)
  );

  twi_dn_merge #(.NCH(NCH)) u_merge (
    .en_i         (chan_en_i),
    .dn_sda_i     (dn_sda_i),
    .up_own_i     (up_own),
    .dn_low_o     (dn_low),
    .dn_sda_drv_o (dn_sda_drv_o)
  );

  twi_sda_lock u_lock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .up_low_i (!up_sda_i),
    .dn_low_i (dn_low),
    .up_own_o (up_own),
    .dn_own_o (dn_own)
  );

  assign up_sda_drv_o = dn_own;
endmodule

// File: rtl/twi_fanout_switch_chk.sv
module twi_fanout_switch_chk #(
  parameter int NCH = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [NCH-1:0] chan_en_i,
  input logic           clk_rev_i,
  input logic           up_scl_i,
  input logic           up_scl_drv_o,
  input logic           up_sda_drv_o,
  input logic [NCH-1:0] dn_scl_drv_o,
  input logic [NCH-1:0] dn_sda_drv_o
);
  // R2
  disabled_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dn_sda_drv_o & ~chan_en_i) == '0);

  // R3
  fwd_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_rev_i && !up_scl_i) |=> dn_scl_drv_o == $past(chan_en_i));

  // R4
  rev_dn_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_rev_i |=> dn_scl_drv_o == '0);

  // R5
  fwd_no_stretch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_rev_i |=> !up_scl_drv_o);

  // R6
  sda_one_owner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(up_sda_drv_o && (dn_sda_drv_o != '0)));

  // R8
  release_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(up_sda_drv_o) |=> (!up_sda_drv_o && dn_sda_drv_o == '0));
endmodule

bind twi_fanout_switch twi_fanout_switch_chk #(.NCH(NCH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .chan_en_i    (chan_en_i),
  .clk_rev_i    (clk_rev_i),
  .up_scl_i     (up_scl_i),
  .up_scl_drv_o (up_scl_drv_o),
  .up_sda_drv_o (up_sda_drv_o),
  .dn_scl_drv_o (dn_scl_drv_o),
  .dn_sda_drv_o (dn_sda_drv_o)
);

// File: tb/twi_fanout_switch_tb_top.sv
module twi_fanout_switch_tb_top;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic [N-1:0] en = '0;
  logic rev = 1'b0;
  logic x_up_scl = 1'b0, x_up_sda = 1'b0;
  logic [N-1:0] x_dn_scl = '0, x_dn_sda = '0;

  logic up_scl_drv, up_sda_drv;
  logic [N-1:0] dn_scl_drv, dn_sda_drv;
  logic up_scl, up_sda;
  logic [N-1:0] dn_scl, dn_sda;

  // open-drain lines: low when either side pulls
  assign up_scl = ~(x_up_scl | up_scl_drv);
  assign up_sda = ~(x_up_sda | up_sda_drv);
  assign dn_scl = ~(x_dn_scl | dn_scl_drv);
  assign dn_sda = ~(x_dn_sda | dn_sda_drv);

  always #5 clk = ~clk;

  twi_fanout_switch #(.NCH(N)) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .chan_en_i    (en),
    .clk_rev_i    (rev),
    .up_scl_i     (up_scl),
    .up_scl_drv_o (up_scl_drv),
    .up_sda_i     (up_sda),
    .up_sda_drv_o (up_sda_drv),
    .dn_scl_i     (dn_scl),
    .dn_scl_drv_o (dn_scl_drv),
    .dn_sda_i     (dn_sda),
    .dn_sda_drv_o (dn_sda_drv)
  );

  int checks = 0;
  int errors = 0;
  bit mdl_on = 1'b0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model built from the requirements: 0 idle, 1 up, 2 dn, 3 release
  logic [1:0] m_st;
  logic [N-1:0] m_dscl;
  logic m_uscl;

  function automatic logic [N-1:0] exp_dn_sda(input logic [1:0] st, input logic [N-1:0] e);
    return (st == 2'd1) ? e : '0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st <= 2'd0; m_dscl <= '0; m_uscl <= 1'b0;
    end else begin
      m_dscl <= (!rev && !up_scl) ? en : '0;
      m_uscl <= rev && ((en & ~dn_scl) != '0);
      case (m_st)
        2'd0: if (!up_sda) m_st <= 2'd1; else if ((en & ~dn_sda) != '0) m_st <= 2'd2;
        2'd1: if (up_sda) m_st <= 2'd3;
        2'd2: if ((en & ~dn_sda) == '0) m_st <= 2'd3;
        default: m_st <= 2'd0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (mdl_on && rst_n && !done) begin
      check(dn_scl_drv == m_dscl, "R3", dn_scl_drv, m_dscl);
      check(up_scl_drv == m_uscl, "R4", up_scl_drv, m_uscl);
      check(dn_sda_drv == exp_dn_sda(m_st, en), "R6", dn_sda_drv, exp_dn_sda(m_st, en));
      check(up_sda_drv == (m_st == 2'd2), "R7", up_sda_drv, m_st == 2'd2);
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic quiet();
    x_up_scl = 0; x_up_sda = 0; x_dn_scl = '0; x_dn_sda = '0;
    repeat (3) tick();
  endtask

  initial begin
    #2 rst_n = 1'b0;
    x_up_sda = 1; x_up_scl = 1; x_dn_sda = '1; x_dn_scl = '1; en = '1; rev = 1;
    repeat (3) @(negedge clk);
    // R1: reset holds every drive off
    check({up_scl_drv, up_sda_drv, dn_scl_drv, dn_sda_drv} == '0, "R1", {up_scl_drv, up_sda_drv, dn_scl_drv, dn_sda_drv}, 0);
    x_up_sda = 0; x_up_scl = 0; x_dn_sda = '0; x_dn_scl = '0; en = '0; rev = 0;
    rst_n = 1'b1;
    tick();
    check({up_scl_drv, up_sda_drv, dn_scl_drv, dn_sda_drv} == '0, "R1", {up_scl_drv, up_sda_drv, dn_scl_drv, dn_sda_drv}, 0);
    mdl_on = 1'b1;

    // R3 forward copy onto enabled channels only (R2)
    en = 4'b0101; x_up_scl = 1; tick();
    check(dn_scl_drv == 4'b0101, "R3", dn_scl_drv, 4'b0101);
    // R5 downstream held low, no stretch upstream
    x_dn_scl = 4'b1111; tick();
    check(up_scl_drv == 1'b0, "R5", up_scl_drv, 0);
    quiet();

    // R4 reverse: disabled channel low ignored (R2), enabled low drives up
    rev = 1; en = 4'b0011; x_dn_scl = 4'b1000; tick();
    check(up_scl_drv == 1'b0, "R2", up_scl_drv, 0);
    x_dn_scl = 4'b1010; tick();
    check(up_scl_drv == 1'b1, "R4", up_scl_drv, 1);
    check(dn_scl_drv == '0, "R4", dn_scl_drv, 0);
    rev = 0; quiet();

    // R6 + R8 hand-over: master low, slave holds low on channel 0
    en = 4'b0001; x_up_sda = 1; tick();
    check(dn_sda_drv == 4'b0001, "R6", dn_sda_drv, 4'b0001);
    x_dn_sda = 4'b0001; tick();
    check(up_sda_drv == 1'b0, "R6", up_sda_drv, 0);
    x_up_sda = 0; tick();
    check({up_sda_drv, dn_sda_drv} == '0, "R8", {up_sda_drv, dn_sda_drv}, 0);
    tick();
    check({up_sda_drv, dn_sda_drv} == '0, "R8", {up_sda_drv, dn_sda_drv}, 0);
    tick();
    check(up_sda_drv == 1'b1, "R8", up_sda_drv, 1);
    quiet();

    // R9 tie goes upstream
    en = 4'b0010; x_up_sda = 1; x_dn_sda = 4'b0010; tick();
    check(dn_sda_drv == 4'b0010 && !up_sda_drv, "R9", {up_sda_drv, dn_sda_drv}, 5'b00010);
    quiet();

    // R10 wired-AND of enabled data; disabled low ignored (R2)
    en = 4'b0011; x_dn_sda = 4'b0110; tick();
    check(up_sda_drv == 1'b1, "R10", up_sda_drv, 1);
    x_dn_sda = 4'b0100; tick();
    check(up_sda_drv == 1'b0, "R10", up_sda_drv, 0);
    repeat (3) tick();
    check(up_sda_drv == 1'b0, "R2", up_sda_drv, 0);
    quiet();

    // R7 downstream owner keeps upstream low while upstream is seen low
    en = 4'b1000; x_dn_sda = 4'b1000; tick();
    check(up_sda_drv == 1'b1 && dn_sda_drv == '0, "R7", {up_sda_drv, dn_sda_drv}, 5'b10000);
    // R1 reset mid-lock clears ownership
    rst_n = 0; #1;
    check(up_sda_drv == 1'b0, "R1", up_sda_drv, 0);
    @(negedge clk); rst_n = 1; quiet();

    // constrained random traffic against the model
    begin
      void'($urandom(32'h5eed_1234));
      for (int i = 0; i < 4000; i++) begin
        if ($urandom_range(0, 63) == 0) en = 4'($urandom);
        if ($urandom_range(0, 127) == 0) rev = ~rev;
        if ($urandom_range(0, 7) == 0) x_up_scl = ~x_up_scl;
        if ($urandom_range(0, 9) == 0) x_up_sda = ~x_up_sda;
        for (int c = 0; c < N; c++) begin
          if ($urandom_range(0, 11) == 0) x_dn_scl[c] = ~x_dn_scl[c];
          if ($urandom_range(0, 13) == 0) x_dn_sda[c] = ~x_dn_sda[c];
        end
        tick();
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule